// File: doc/BRIEF.md
# Register Pair Arithmetic Unit

This block holds the four 16-bit register pairs of an 8-bit processor core (two general pairs, the memory pointer pair and the stack pointer) and performs the 16-bit arithmetic that operates on them. Three operations exist: add one to a chosen pair, subtract one from a chosen pair, and add a chosen pair into the pointer pair HL. Only the addition touches a flag, the carry. The increment and decrement wrap around at 16 bits.

The core issues an operation with a one-cycle start strobe, an operation code and a 2-bit pair field. The unit then stays busy for as many clock cycles as the operation has processor states. The timing select input chooses between the shorter (5-state) and the longer (6-state) increment/decrement timing; addition is 10 states in both. When the last state ends, a one-cycle done pulse appears and the result is already visible on the pair outputs during that pulse. While idle, the core's ordinary write-back path can load any pair directly.

Top module: `rpair_alu`

## Requirements
- R1: Operation code 00 (increment) writes the selected pair plus one, modulo 2^16 (FFFF becomes 0000).
- R2: Operation code 01 (decrement) writes the selected pair minus one, modulo 2^16 (0000 becomes FFFF).
- R3: Increment and decrement leave the carry output and the three non-selected pairs unchanged.
- R4: Operation code 10 (add) writes the low 16 bits of HL plus the selected pair into HL; selecting HL doubles it; the other pairs are unchanged.
- R5: Add sets the carry output to the carry out of bit 15 of the sum and clears it when there is none.
- R6: After an accepted start, busy is high for exactly N cycles, then busy is low and done is high for exactly one cycle, with the new pair and carry values visible in that cycle; N is 10 for add, 5 for increment/decrement with the timing select at 1, and 6 with it at 0.
- R7: A start strobe or a load request that arrives while busy has no effect: neither the running operation's length nor its result, nor any pair, changes because of it.
- R8: The pair field selects 00 = BC, 01 = DE, 10 = HL, 11 = SP; pair k appears on output bits 16k+15 down to 16k.
- R9: A start strobe with operation code 11 is not accepted: busy stays low and no pair or carry changes.
- R10: When not busy, a load request writes the load value into the pair named by the load field; it is visible the cycle after.
- R11: Reset (active low) clears all pairs and the carry and holds busy and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: 00 increment, 01 decrement, 10 add into HL, 11 none |
| sel_i | input | SEL_W | Pair field of the operation |
| legacy_i | input | 1 | 1 = 5-state increment/decrement timing, 0 = 6-state |
| ld_en_i | input | 1 | Direct write-back request to a pair |
| ld_sel_i | input | SEL_W | Pair addressed by the write-back |
| ld_val_i | input | WORD_W | Write-back value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pairs_o | output | NPAIR*WORD_W | All pair contents, pair k in slice k |
| carry_o | output | 1 | Carry flag |

## Verification
The bench builds the unit with its defaults: 16-bit pairs, a 2-bit pair field and state counts of 6, 5 and 10. At that size every combination of operation, pair and timing select can be swept with a set of corner operands (zero, one, the sign boundary, the two top values and mixed patterns), so wrap at both ends, carry out of bit 15, HL added to itself and every busy length are all reached. The bench also drives a start and a load into the middle of a running operation and tries the unused operation code, comparing against results computed arithmetically.

// File: rtl/rpair_pkg.sv
package rpair_pkg;

    typedef enum logic [1:0] {
        OP_INC  = 2'b00,
        OP_DEC  = 2'b01,
        OP_ADD  = 2'b10,
        OP_NONE = 2'b11
    } rp_op_e;

endpackage

// File: rtl/rpair_timer.sv
// Operation sequencer: latches the request and counts processor states.
module rpair_timer
    import rpair_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int ST_EXT = 6,
    parameter int ST_LEG = 5,
    parameter int ST_ADD = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             legacy_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fin_o,
    output rp_op_e           op_o,
    output logic [SEL_W-1:0] sel_o
);

    localparam int MAX_ST = (ST_ADD > ST_EXT) ? ((ST_ADD > ST_LEG) ? ST_ADD : ST_LEG)
                                              : ((ST_EXT > ST_LEG) ? ST_EXT : ST_LEG);
    localparam int CNT_W  = $clog2(MAX_ST + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        rp_op_e           op;
        logic [SEL_W-1:0] sel;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    rp_op_e  op_req;
    int      n_states;

    assign op_req = rp_op_e'(op_i);
    assign fin_o  = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        if (op_req == OP_ADD)  n_states = ST_ADD;
        else if (legacy_i)     n_states = ST_LEG;
        else                   n_states = ST_EXT;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_i && (op_req != OP_NONE)) begin
            st_d.busy = 1'b1;
            st_d.op   = op_req;
            st_d.sel  = sel_i;
            st_d.cnt  = CNT_W'(n_states - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{busy: 1'b0, done: 1'b0, cnt: '0, op: OP_NONE, sel: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign op_o   = st_q.op;
    assign sel_o  = st_q.sel;

endmodule

// File: rtl/rpair_calc.sv
// 16-bit datapath: increment, decrement or add with carry out.
module rpair_calc
    import rpair_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  rp_op_e            op_i,
    input  logic [WORD_W-1:0] opnd_i,
    input  logic [WORD_W-1:0] hl_i,
    output logic [WORD_W-1:0] res_o,
    output logic              cy_o
);

    logic [WORD_W:0] sum;

    always_comb begin
        unique case (op_i)
            OP_INC:  sum = {1'b0, opnd_i} + (WORD_W+1)'(1);
            OP_DEC:  sum = {1'b0, opnd_i} - (WORD_W+1)'(1);
            OP_ADD:  sum = {1'b0, opnd_i} + {1'b0, hl_i};
            default: sum = {1'b0, opnd_i};
        endcase
    end

    assign res_o = sum[WORD_W-1:0];
    assign cy_o  = sum[WORD_W];

endmodule

// File: rtl/rpair_alu.sv
// Register pair file with sequenced 16-bit arithmetic.
module rpair_alu
    import rpair_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 2,
    parameter int ST_EXT = 6,
    parameter int ST_LEG = 5,
    parameter int ST_ADD = 10,
    localparam int NPAIR = 1 << SEL_W
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [1:0]              op_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic                    legacy_i,
    input  logic                    ld_en_i,
    input  logic [SEL_W-1:0]        ld_sel_i,
    input  logic [WORD_W-1:0]       ld_val_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [NPAIR*WORD_W-1:0] pairs_o,
    output logic                    carry_o
);

    localparam logic [SEL_W-1:0] HL_SEL = SEL_W'(2);

    typedef struct packed {
        logic [NPAIR-1:0][WORD_W-1:0] pr;
        logic                         cy;
    } rf_t;

    rf_t               rf_d, rf_q;
    logic              fin_w;
    rp_op_e            op_q_w;
    logic [SEL_W-1:0]  sel_q_w;
    logic [SEL_W-1:0]  tgt_sel;
    logic [WORD_W-1:0] opnd, res;
    logic              cy_new, ld_ok;
    logic [WORD_W-1:0] pair_nx [NPAIR];

    rpair_timer #(
        .SEL_W (SEL_W),
        .ST_EXT(ST_EXT),
        .ST_LEG(ST_LEG),
        .ST_ADD(ST_ADD)
    ) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .op_i    (op_i),
        .sel_i   (sel_i),
        .legacy_i(legacy_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .fin_o   (fin_w),
        .op_o    (op_q_w),
        .sel_o   (sel_q_w)
    );

    assign opnd    = rf_q.pr[sel_q_w];
    assign tgt_sel = (op_q_w == OP_ADD) ? HL_SEL : sel_q_w;
    assign ld_ok   = ld_en_i && !busy_o;

    rpair_calc #(.WORD_W(WORD_W)) u_calc (
        .op_i  (op_q_w),
        .opnd_i(opnd),
        .hl_i  (rf_q.pr[HL_SEL]),
        .res_o (res),
        .cy_o  (cy_new)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign pair_nx[g] = (fin_w && (tgt_sel == SEL_W'(g))) ? res :
                            (ld_ok && (ld_sel_i == SEL_W'(g))) ? ld_val_i :
                            rf_q.pr[g];
    end

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NPAIR; i++) begin
            rf_d.pr[i] = pair_nx[i];
        end
        if (fin_w && (op_q_w == OP_ADD)) begin
            rf_d.cy = cy_new;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign pairs_o = rf_q.pr;
    assign carry_o = rf_q.cy;

endmodule

// File: rtl/rpair_alu_chk.sv
// Protocol and arithmetic checker, attached to the top by bind.
module rpair_alu_chk
    import rpair_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 2,
    parameter int NPAIR  = 4
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    start_i,
    input logic [1:0]              op_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic [NPAIR*WORD_W-1:0] pairs_o,
    input logic                    carry_o,
    input logic                    fin_i,
    input rp_op_e                  op_q_i,
    input logic [SEL_W-1:0]        sel_q_i
);

    logic [WORD_W-1:0] cur_pair;
    assign cur_pair = pairs_o[sel_q_i*WORD_W +: WORD_W];

    assert_busy_done_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    assert_done_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_hold_while_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (done_o || $stable(pairs_o)));

    assert_carry_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin_i && (op_q_i != OP_ADD)) |=> $stable(carry_o));

    assert_inc_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin_i && (op_q_i == OP_INC)) |=> (cur_pair == WORD_W'($past(cur_pair) + 1'b1)));

    assert_dec_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin_i && (op_q_i == OP_DEC)) |=> (cur_pair == WORD_W'($past(cur_pair) - 1'b1)));

    assert_unused_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !(start_i && (op_i != 2'b11))) |=> !busy_o);

endmodule

bind rpair_alu rpair_alu_chk #(
    .WORD_W(WORD_W),
    .SEL_W (SEL_W),
    .NPAIR (NPAIR)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .op_i   (op_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .pairs_o(pairs_o),
    .carry_o(carry_o),
    .fin_i  (fin_w),
    .op_q_i (op_q_w),
    .sel_q_i(sel_q_w)
);

// File: tb/rpair_alu_tb_top.sv
module rpair_alu_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [1:0]  sel_i = 2'b00;
    logic        legacy_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [1:0]  ld_sel_i = 2'b00;
    logic [15:0] ld_val_i = '0;
    logic        busy_o, done_o, carry_o;
    logic [63:0] pairs_o;

    int          errors = 0;
    int          checks = 0;
    logic [15:0] m [4];
    logic        mc;

    always #4 clk_i = ~clk_i;

    rpair_alu dut_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .op_i    (op_i),
        .sel_i   (sel_i),
        .legacy_i(legacy_i),
        .ld_en_i (ld_en_i),
        .ld_sel_i(ld_sel_i),
        .ld_val_i(ld_val_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .pairs_o (pairs_o),
        .carry_o (carry_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pr(input int k);
        return pairs_o[16*k +: 16];
    endfunction

    task automatic check_all(input string tag);
        for (int k = 0; k < 4; k++) begin
            chk(pr(k) == m[k], tag, pr(k), m[k]);
        end
    endtask

    // R10: direct load while idle
    task automatic load(input logic [1:0] sel, input logic [15:0] val);
        ld_en_i  = 1'b1;
        ld_sel_i = sel;
        ld_val_i = val;
        @(negedge clk_i);
        ld_en_i = 1'b0;
        m[sel]  = val;
        chk(pr(sel) == val, "R10 load", pr(sel), val);
    endtask

    task automatic run(input logic [1:0] op, input logic [1:0] sel,
                       input logic leg, input bit inject);
        int          n_exp;
        int          nb;
        logic [16:0] s;
        string       tag;
        n_exp = (op == 2'b10) ? 10 : (leg ? 5 : 6);
        case (op)
            2'b00: begin s = {1'b0, m[sel]} + 17'd1; tag = "R1 R8 increment"; end
            2'b01: begin s = {1'b0, m[sel]} - 17'd1; tag = "R2 R8 decrement"; end
            default: begin s = {1'b0, m[sel]} + {1'b0, m[2]}; tag = "R4 R8 add"; end
        endcase
        start_i  = 1'b1;
        op_i     = op;
        sel_i    = sel;
        legacy_i = leg;
        @(negedge clk_i);
        start_i = 1'b0;
        nb = 0;
        while (busy_o && nb < 40) begin
            nb++;
            @(negedge clk_i);
            if (inject && nb == 2) begin
                start_i  = 1'b1;
                op_i     = (op == 2'b10) ? 2'b00 : 2'b10;
                sel_i    = ~sel;
                legacy_i = ~leg;
                ld_en_i  = 1'b1;
                ld_sel_i = sel;
                ld_val_i = 16'h5A5A;
            end else if (inject && nb == 3) begin
                start_i = 1'b0;
                ld_en_i = 1'b0;
            end
        end
        chk(nb == n_exp, inject ? "R7 busy length with injected start" : "R6 busy length",
            nb, n_exp);
        chk(done_o == 1'b1, "R6 done after busy", done_o, 1);
        if (op == 2'b10) begin
            m[2] = s[15:0];
            mc   = s[16];
            chk(carry_o == mc, "R5 add carry", carry_o, mc);
        end else begin
            m[sel] = s[15:0];
            chk(carry_o == mc, "R3 carry kept", carry_o, mc);
        end
        check_all(inject ? "R7 result with injected start" : tag);
        @(negedge clk_i);
        chk(done_o == 1'b0, "R6 done single cycle", done_o, 0);
        chk(busy_o == 1'b0, "R6 idle after done", busy_o, 0);
    endtask

    initial begin
        logic [15:0] vals [8];
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
        vals[4] = 16'hFFFE; vals[5] = 16'hFFFF; vals[6] = 16'h1234; vals[7] = 16'hA5C3;
        for (int k = 0; k < 4; k++) m[k] = '0;
        mc = 1'b0;

        repeat (3) @(negedge clk_i);
        // R11: reset state
        check_all("R11 reset pairs");
        chk(carry_o == 1'b0, "R11 reset carry", carry_o, 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R11 reset busy/done", {busy_o, done_o}, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R2 / R1 wrap from reset value
        run(2'b01, 2'b00, 1'b0, 1'b0);
        chk(pr(0) == 16'hFFFF, "R2 wrap 0000-1", pr(0), 16'hFFFF);
        run(2'b00, 2'b00, 1'b1, 1'b0);
        chk(pr(0) == 16'h0000, "R1 wrap FFFF+1", pr(0), 0);

        // R3: carry set by add survives increment and decrement
        load(2'd2, 16'hFFFF);
        load(2'd1, 16'h0001);
        run(2'b10, 2'b01, 1'b0, 1'b0);
        chk(carry_o == 1'b1 && pr(2) == 16'h0000, "R5 carry out of bit 15",
            {carry_o, pr(2)}, 17'h10000);
        run(2'b00, 2'b11, 1'b0, 1'b0);
        run(2'b01, 2'b01, 1'b1, 1'b0);
        chk(carry_o == 1'b1, "R3 carry still set", carry_o, 1);

        // R9: unused operation code
        start_i = 1'b1;
        op_i    = 2'b11;
        sel_i   = 2'b10;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(busy_o == 1'b0, "R9 code 11 not accepted", busy_o, 0);
        @(negedge clk_i);
        check_all("R9 pairs unchanged");
        chk(carry_o == mc, "R9 carry unchanged", carry_o, mc);

        // Sweep of variant, operation, pair and corner operands
        for (int lg = 0; lg < 2; lg++) begin
            for (int op = 0; op < 3; op++) begin
                for (int sl = 0; sl < 4; sl++) begin
                    for (int k = 0; k < 8; k++) begin
                        load(2'(sl), vals[k]);
                        if (sl != 2) load(2'd2, vals[(k + 3) % 8]);
                        run(2'(op), 2'(sl), 1'(lg), k == 5);
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule